// File: doc/BRIEF.md
# Sparse Census Transform Unit

This block turns a raster-ordered stream of 8-bit greyscale pixels into a stream of 7-bit census signatures, one for each accepted pixel. Each signature describes the local texture around a centre pixel. Seven neighbours, taken on a sparse lattice of a 5x5 neighbourhood, are each compared with the centre. The result suits a later matching stage that compares signatures by Hamming distance.

Each input pixel is fetched from the stream only once. A line memory with one word per image column keeps the four rows above the current one. On every accepted pixel, that column's word is read and rebuilt with the new pixel. It is then written back whole. A small sliding window collects the sampled rows, and the centre pixel travels through a dedicated register on the way. Frames follow one another with no gap, and the row and column counters wrap. Border signatures are still emitted, but they carry a flag. Because of the window's lag, the last rows of one frame are emitted while the first rows of the next frame are being accepted.

Top module: `sct_top`

## Requirements
- R1: While `rst_n` is low, `pix_ready` and `sig_valid` are 0. `pix_ready` becomes 1 at the first rising clock edge after reset is released and stays 1 from then on.
- R2: Signature bit k compares neighbour k with the centre. The neighbours, as (row, column) offsets from the centre, are: bit 0 (-2,-2), bit 1 (-2,0), bit 2 (-2,+2), bit 3 (0,-2), bit 4 (0,+2), bit 5 (+2,-2), bit 6 (+2,+2).
- R3: A signature bit is 1 exactly when its neighbour is strictly smaller than the centre. An equal or larger neighbour gives 0.
- R4: `sig_edge` is 1 exactly when the centre lies in row 0, row 1, row HEIGHT-2 or row HEIGHT-1, or in column 0, column 1, column WIDTH-2 or column WIDTH-1 of its frame.
- R5: Let n be a pixel's index in the accepted stream. The signature whose centre is pixel n is shown with `sig_valid` high for one cycle. That cycle directly follows the handshake of pixel n+2*WIDTH+2. `sig_valid` is never high in any other cycle. Between pulses, `sig_bits` and `sig_edge` hold their last values. Both are 0 after reset.
- R6: A cycle with `pix_valid` low does not advance the stream position. The stored data and the counters are unchanged.
- R7: Pixel positions before the first pixel accepted after reset read as 0. The first signature after reset is for stream index 0.
- R8: Frames of WIDTH x HEIGHT pixels follow one another. The row count wraps after HEIGHT rows, and the window carries on across the frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Input pixel present |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| pix_data | input | 8 | Greyscale pixel value |
| sig_valid | output | 1 | One-cycle pulse marking a new signature |
| sig_bits | output | 7 | Census signature, bit mapping per R2 |
| sig_edge | output | 1 | Centre lies in the two-pixel frame border |

## Verification
Several properties are checked on every cycle. `pix_ready` never drops once it has risen. A `sig_valid` pulse always follows a handshake. The outputs stay still between pulses. A centre taken from the two columns at either side is always flagged. The bench's scenarios are what show the signature values themselves, including ties between neighbour and centre on flat and low-contrast images. They also show the exact lag of 2*WIDTH+2 pixels when input has gaps, the zero fill before the first row, the flagging of the border rows, and the wrap across frames.

// File: rtl/sct_pkg.sv
package sct_pkg;
    localparam int PIX_W  = 8;            // pixel width
    localparam int SIG_W  = 7;            // compared neighbours per signature
    localparam int MARGIN = 2;            // half window span
    localparam int TAPS   = 2 * MARGIN + 1;
    localparam int HIST   = 2 * MARGIN;   // rows above current kept per column

    typedef logic [PIX_W-1:0]            pix_t;
    typedef logic [HIST-1:0][PIX_W-1:0]  lbword_t;  // [0] = one row above
    typedef logic [TAPS-1:0][PIX_W-1:0]  wrow_t;    // [0] = newest column
    typedef logic [SIG_W-1:0][PIX_W-1:0] nbr_t;
endpackage

// File: rtl/sct_linebuf.sv
module sct_linebuf
    import sct_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] col,
    input  pix_t          pix_in,
    output pix_t          up_near,   // MARGIN rows above
    output pix_t          up_far     // HIST rows above
);
    lbword_t [WIDTH-1:0] mem_d, mem_q;
    lbword_t             rd_word;

    assign rd_word = mem_q[col];
    assign up_near = rd_word[MARGIN-1];
    assign up_far  = rd_word[HIST-1];

    // the column word is rebuilt in full and written back in one go
    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[col] = {rd_word[HIST-2:0], pix_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/sct_window.sv
module sct_window
    import sct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift,
    input  pix_t col_top,
    input  pix_t col_mid,
    input  pix_t col_bot,
    output nbr_t nbr_nxt,
    output pix_t ctr_nxt
);
    typedef struct packed {
        wrow_t                        top;
        wrow_t                        bot;
        logic [MARGIN-1:0][PIX_W-1:0] near;  // centre row, right of centre
        pix_t                         ctr;   // dedicated centre register
        logic [MARGIN-1:0][PIX_W-1:0] far;   // centre row, left of centre
    } win_s;

    win_s win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (shift) begin
            win_d.top[0]  = col_top;
            win_d.bot[0]  = col_bot;
            win_d.near[0] = col_mid;
            win_d.ctr     = win_q.near[MARGIN-1];
            win_d.far[0]  = win_q.ctr;
            for (int i = 1; i < TAPS; i++) begin
                win_d.top[i] = win_q.top[i-1];
                win_d.bot[i] = win_q.bot[i-1];
            end
            for (int i = 1; i < MARGIN; i++) begin
                win_d.near[i] = win_q.near[i-1];
                win_d.far[i]  = win_q.far[i-1];
            end
        end
    end

    // sampled neighbours in signature bit order
    assign nbr_nxt[0] = win_d.top[TAPS-1];
    assign nbr_nxt[1] = win_d.top[MARGIN];
    assign nbr_nxt[2] = win_d.top[0];
    assign nbr_nxt[3] = win_d.far[MARGIN-1];
    assign nbr_nxt[4] = win_d.near[0];
    assign nbr_nxt[5] = win_d.bot[TAPS-1];
    assign nbr_nxt[6] = win_d.bot[0];
    assign ctr_nxt    = win_d.ctr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/sct_compare.sv
module sct_compare
    import sct_pkg::*;
(
    input  nbr_t             nbr,
    input  pix_t             ctr,
    output logic [SIG_W-1:0] bits
);
    for (genvar g = 0; g < SIG_W; g++) begin : g_cmp
        assign bits[g] = (nbr[g] < ctr);
    end
endmodule

// File: rtl/sct_top.sv
module sct_top
    import sct_pkg::*;
#(
    parameter int WIDTH  = 64,
    parameter int HEIGHT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic [PIX_W-1:0] pix_data,
    output logic             sig_valid,
    output logic [SIG_W-1:0] sig_bits,
    output logic             sig_edge
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int RW = (HEIGHT > 1) ? $clog2(HEIGHT) : 1;

    typedef struct packed {
        logic [CW-1:0]    col;
        logic [RW-1:0]    row;
        logic             primed;
        logic             ready;
        logic             ov;
        logic [SIG_W-1:0] obits;
        logic             oedge;
    } top_s;

    top_s st_d, st_q;

    logic             accept;
    pix_t             up_near, up_far, ctr_nxt;
    nbr_t             nbr_nxt;
    logic [SIG_W-1:0] cmp_bits;

    assign accept = pix_valid & st_q.ready;

    sct_linebuf #(.WIDTH(WIDTH)) i_linebuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .col     (st_q.col),
        .pix_in  (pix_data),
        .up_near (up_near),
        .up_far  (up_far)
    );

    sct_window i_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift   (accept),
        .col_top (up_far),
        .col_mid (up_near),
        .col_bot (pix_data),
        .nbr_nxt (nbr_nxt),
        .ctr_nxt (ctr_nxt)
    );

    sct_compare i_compare (
        .nbr  (nbr_nxt),
        .ctr  (ctr_nxt),
        .bits (cmp_bits)
    );

    always_comb begin
        int rr, crow, ccol;
        logic border;
        st_d = st_q;
        st_d.ready = 1'b1;
        st_d.ov    = 1'b0;

        // centre lags the incoming pixel by MARGIN rows and MARGIN columns
        if (int'(st_q.col) >= MARGIN) begin
            rr   = int'(st_q.row);
            ccol = int'(st_q.col) - MARGIN;
        end else begin
            rr   = (st_q.row == '0) ? HEIGHT - 1 : int'(st_q.row) - 1;
            ccol = int'(st_q.col) + WIDTH - MARGIN;
        end
        crow = (rr >= MARGIN) ? rr - MARGIN : rr + HEIGHT - MARGIN;
        border = (crow < MARGIN) || (crow >= HEIGHT - MARGIN) ||
                 (ccol < MARGIN) || (ccol >= WIDTH - MARGIN);

        if (accept) begin
            if (st_q.col == CW'(WIDTH - 1)) begin
                st_d.col = '0;
                st_d.row = (st_q.row == RW'(HEIGHT - 1)) ? '0 : st_q.row + 1'b1;
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
            st_d.ov = st_q.primed ||
                      ((int'(st_q.row) == MARGIN) && (int'(st_q.col) == MARGIN));
            st_d.primed = st_d.ov;
            if (st_d.ov) begin
                st_d.obits = cmp_bits;
                st_d.oedge = border;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_ready = st_q.ready;
    assign sig_valid = st_q.ov;
    assign sig_bits  = st_q.obits;
    assign sig_edge  = st_q.oedge;
endmodule

// File: rtl/sct_checker.sv
module sct_checker
    import sct_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic             sig_valid,
    input logic [SIG_W-1:0] sig_bits,
    input logic             sig_edge
);
    logic [31:0] chk_col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_col_q <= '0;
        end else if (pix_valid && pix_ready) begin
            chk_col_q <= (chk_col_q == 32'(WIDTH - 1)) ? '0 : chk_col_q + 1;
        end
    end

    a_r1_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_ready) |-> pix_ready);

    a_r1_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_ready) |-> !sig_valid);

    a_r5_pulse_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |-> $past(pix_valid && pix_ready));

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_valid |-> ($stable(sig_bits) && $stable(sig_edge)));

    // centre column is 0, 1, WIDTH-2 or WIDTH-1 when the input column is below 4
    a_r4_side_columns_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_valid && ($past(chk_col_q) < 32'd4)) |-> sig_edge);
endmodule

bind sct_top sct_checker #(.WIDTH(WIDTH)) i_sct_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .sig_valid (sig_valid),
    .sig_bits  (sig_bits),
    .sig_edge  (sig_edge)
);

// File: tb/test_sct_top.sv
module test_sct_top;
    localparam int W = 64;
    localparam int H = 16;
    localparam int M = 2;
    localparam int LAG = 2 * W + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_data = 8'd0;
    logic       pix_ready, sig_valid, sig_edge;
    logic [6:0] sig_bits;

    always #2 clk = ~clk;

    sct_top #(.WIDTH(W), .HEIGHT(H)) i_sct_top (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .sig_valid(sig_valid), .sig_bits(sig_bits),
        .sig_edge(sig_edge)
    );

    int         n_vec = 0;
    int         n_bad = 0;
    int         m = 0;
    logic [7:0] hist [0:4095];
    logic       e_valid = 1'b0;
    logic [6:0] e_bits = '0, last_bits = '0;
    logic       e_edge = 1'b0, last_edge = 1'b0;

    function automatic logic [7:0] px(int idx);
        return (idx < 0) ? 8'd0 : hist[idx % 4096];
    endfunction

    function automatic logic [6:0] exp_sig(int n);
        int dr [7] = '{-2, -2, -2, 0, 0, 2, 2};
        int dc [7] = '{-2, 0, 2, -2, 2, -2, 2};
        logic [6:0] s;
        for (int k = 0; k < 7; k++) begin
            s[k] = px(n + dr[k] * W + dc[k]) < px(n);
        end
        return s;
    endfunction

    function automatic logic exp_border(int n);
        int r = (n / W) % H;
        int c = n % W;
        return (r < M) || (r >= H - M) || (c < M) || (c >= W - M);
    endfunction

    task automatic fail(string what, int act, int exp);
        n_bad++;
        $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    endtask

    task automatic check_out();
        n_vec++;
        if (sig_valid !== e_valid) fail("R5/R6/R7 sig_valid timing", int'(sig_valid), int'(e_valid));
        if (e_valid) begin
            n_vec++;
            if (sig_bits !== e_bits) fail("R2/R3 signature bits", int'(sig_bits), int'(e_bits));
            n_vec++;
            if (sig_edge !== e_edge) fail("R4/R8 border flag", int'(sig_edge), int'(e_edge));
            last_bits = e_bits;
            last_edge = e_edge;
        end else begin
            n_vec++;
            if ({sig_bits, sig_edge} !== {last_bits, last_edge})
                fail("R5 hold between pulses", int'({sig_bits, sig_edge}), int'({last_bits, last_edge}));
        end
    endtask

    task automatic step(logic v, logic [7:0] d);
        @(negedge clk);
        check_out();
        pix_valid = v;
        pix_data  = d;
        e_valid   = 1'b0;
        if (v && pix_ready) begin
            hist[m % 4096] = d;
            if (m >= LAG) begin
                e_valid = 1'b1;
                e_bits  = exp_sig(m - LAG);
                e_edge  = exp_border(m - LAG);
            end
            m++;
        end
    endtask

    // mode: 0 random, 1 low-contrast (ties), 2 flat, 3 ramp
    task automatic phase(int steps, int mode, int gap_pct);
        for (int i = 0; i < steps; i++) begin
            logic [7:0] d;
            logic v;
            case (mode)
                0:       d = 8'($urandom);
                1:       d = 8'($urandom % 4);
                2:       d = 8'd100;
                default: d = 8'(m * 5);
            endcase
            v = (($urandom % 100) >= 32'(gap_pct));
            step(v, d);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4096; i++) hist[i] = 8'd0;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            n_vec++;
            if ({pix_ready, sig_valid} !== 2'b00) fail("R1 reset outputs", int'({pix_ready, sig_valid}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (pix_ready !== 1'b1) fail("R1 ready after reset", int'(pix_ready), 1);

        phase(1200, 0, 0);   // R7 first output, R2 random values, no gaps
        phase(1500, 1, 30);  // R3 ties, R6 gaps
        phase(1100, 2, 20);  // R3 flat image gives all zeros
        phase(1000, 3, 40);  // R8 frame wrap with ramp data
        phase(1500, 0, 25);  // R4 borders over several frames
        step(1'b0, 8'd0);
        @(negedge clk);
        check_out();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL R5 watchdog: actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule